// File: doc/BRIEF.md
# Cascaded Pair-Code Systematic Encoder

This block turns a 16-bit message into a 32-bit rate-1/2 systematic codeword. It does not use a generator matrix. The message passes through a cascade of identical stages. In each stage a two-bit mother code acts on every adjacent bit pair. A fixed perfect-shuffle interleaver sits between every two neighbouring stages. The last stage's output is the parity half, and the message itself is the other half.

A direction input selects reverse operation. In that mode the input word is taken as a parity vector. It is walked back through the stages in reverse order, using the inverted pair equations and the inverse shuffle, and the result is the message that would have produced that parity. One datapath serves both directions.

A valid/ready handshake accepts one word per cycle. The codeword lands in a single output register one cycle after acceptance. It is held there until the consumer takes it.

Top module: `cx_codec`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` is low after that edge. After reset, `in_ready` is high.
- R2: Codeword layout is fixed. `out_word[15:0]` holds the message and `out_word[31:16]` holds the parity. In encode mode (`in_mode`=0) the low half equals the accepted `in_data`.
- R3: The mother code acts on the pair of bits 2j (first, a) and 2j+1 (second, b). Encoding writes b to bit 2j and a XOR b to bit 2j+1. For example, message 0x0002 encodes to parity 0x8080.
- R4: Four mother-code stages are used, with three identical interleavers between them. The interleaver sends bit i to bit (2·i mod 15) for i<15, and keeps bit 15 in place. For example, message 0x0001 encodes to parity 0x8000.
- R5: The mode is sampled with each accepted word. Consecutive words may alternate direction, and each word is processed in its own mode.
- R6: In decode mode (`in_mode`=1), `in_data` is a parity vector. The upper half of the output equals `in_data`, and the lower half is the message whose encoding yields that parity.
- R7: `in_ready` equals `!out_valid || out_ready`. A word accepted at an edge appears on `out_word` with `out_valid` high right after that edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` stays unchanged. Input words offered during that time are not taken.
- R9: When the output is consumed and no new word is accepted at the same edge, `out_valid` goes low. With `out_ready` held high, one word passes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_mode | input | 1 | 0 = encode message, 1 = recover message from parity |
| in_data | input | 16 | Message (encode) or parity (decode) |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | {parity, message} |

## Verification
The hardest situation to reach from the ports combines two things at once. The output register must be stalled, and a new, different word must be pending at the input. A design that wrongly accepts during a stall would silently overwrite the held codeword. To create this, the stimulus holds `out_ready` low for several cycles while a second word is presented, then releases it. Any corruption shows either in the hold comparison or as an extra or shifted entry in the scoreboard. Round trips are a second focus: parity vectors produced by encoding known messages are fed back in decode mode, and the recovered half must equal the original message, with modes alternating word by word under an irregular consumer.

// File: rtl/cxe_pkg.sv
package cxe_pkg;

    parameter int unsigned MSG_W     = 16;
    parameter int unsigned STAGE_CNT = 4;

    typedef enum logic {
        DIR_ENC = 1'b0,
        DIR_DEC = 1'b1
    } dir_e;

    // Perfect-shuffle destination: bit idx moves to (2*idx mod (width-1)),
    // the top bit stays where it is.
    function automatic int unsigned shuffle_dst(input int unsigned idx,
                                                input int unsigned width);
        if (idx == width - 1)
            return idx;
        return (2 * idx) % (width - 1);
    endfunction

endpackage

// File: rtl/cx_pair_cell.sv
module cx_pair_cell
    import cxe_pkg::*;
(
    input  dir_e dir,
    input  logic a_i,
    input  logic b_i,
    output logic x_o,
    output logic y_o
);
    always_comb begin
        if (dir == DIR_ENC) begin
            x_o = b_i;
            y_o = a_i ^ b_i;
        end else begin
            x_o = a_i ^ b_i;
            y_o = a_i;
        end
    end
endmodule

// File: rtl/cx_shuffle.sv
module cx_shuffle
    import cxe_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  dir_e         dir,
    input  logic [W-1:0] in_v,
    output logic [W-1:0] out_v
);
    logic [W-1:0] fwd_v;
    logic [W-1:0] rev_v;

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int unsigned DST = shuffle_dst(i, W);
        assign fwd_v[DST] = in_v[i];
        assign rev_v[i]   = in_v[DST];
    end

    assign out_v = (dir == DIR_ENC) ? fwd_v : rev_v;

    // R4
    always_comb begin
        weight_kept_chk: assert ($countones(out_v) == $countones(in_v))
            else $error("interleaver changed the number of set bits");
    end
endmodule

// File: rtl/cx_lattice.sv
module cx_lattice
    import cxe_pkg::*;
#(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 4
) (
    input  dir_e         dir,
    input  logic [W-1:0] in_v,
    output logic [W-1:0] out_v
);
    localparam int unsigned PAIRS = W / 2;

    for (genvar s = 0; s < STAGES; s++) begin : g_stg
        logic [W-1:0] si;
        logic [W-1:0] mixed;
        logic [W-1:0] so;

        if (s == 0) begin : g_head
            assign si = in_v;
        end else begin : g_link
            assign si = g_stg[s-1].so;
        end

        for (genvar p = 0; p < PAIRS; p++) begin : g_pair
            cx_pair_cell u_cell (
                .dir (dir),
                .a_i (si[2*p]),
                .b_i (si[2*p+1]),
                .x_o (mixed[2*p]),
                .y_o (mixed[2*p+1])
            );
        end

        if (s < STAGES - 1) begin : g_ilv
            cx_shuffle #(.W(W)) u_shuf (
                .dir   (dir),
                .in_v  (mixed),
                .out_v (so)
            );
        end else begin : g_last
            assign so = mixed;
        end
    end

    assign out_v = g_stg[STAGES-1].so;
endmodule

// File: rtl/cx_codec.sv
module cx_codec
    import cxe_pkg::*;
#(
    parameter int unsigned MSG_W  = cxe_pkg::MSG_W,
    parameter int unsigned STAGES = cxe_pkg::STAGE_CNT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_mode,
    input  logic [MSG_W-1:0]   in_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [2*MSG_W-1:0] out_word
);
    localparam int unsigned CW_W = 2 * MSG_W;

    dir_e             dir;
    logic [MSG_W-1:0] lat_out;
    logic [CW_W-1:0]  next_word;
    logic             take;

    assign dir = dir_e'(in_mode);

    cx_lattice #(.W(MSG_W), .STAGES(STAGES)) u_lat (
        .dir   (dir),
        .in_v  (in_data),
        .out_v (lat_out)
    );

    always_comb begin
        if (dir == DIR_ENC)
            next_word = {lat_out, in_data};
        else
            next_word = {in_data, lat_out};
    end

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_word  <= next_word;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid)
        else $error("out_valid set after reset");

    // R7
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid)
        else $error("accepted word not presented");

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_word))
        else $error("stalled output changed");

    // R9
    drain_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && !in_valid |=> !out_valid)
        else $error("consumed output still valid");

    // R2
    msg_half_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && !in_mode |=> out_word[MSG_W-1:0] == $past(in_data))
        else $error("message half differs from input");

    // R6
    par_half_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && in_mode |=> out_word[CW_W-1:MSG_W] == $past(in_data))
        else $error("parity half differs from input");
endmodule

// File: tb/cx_codec_tb.sv
module cx_codec_tb_top;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_ready;
    logic          in_mode;
    logic [W-1:0]  in_data;
    logic          out_valid;
    logic          out_ready;
    logic [2*W-1:0] out_word;

    int checks = 0;
    int fails  = 0;
    int rdy_pat = 0;
    int cyc = 0;
    bit mon_on = 0;

    logic [2*W-1:0] exp_q [$];
    string          tag_q [$];

    always #5 clk = ~clk;

    cx_codec dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_mode   (in_mode),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word)
    );

    // reference: encoding from the stated pair equations and shuffle rule
    function automatic int dst_of(input int i);
        return (i == W - 1) ? i : (2 * i) % (W - 1);
    endfunction

    function automatic logic [W-1:0] ref_enc(input logic [W-1:0] m);
        logic [W-1:0] v, t;
        v = m;
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < W / 2; p++) begin
                t[2*p]   = v[2*p+1];
                t[2*p+1] = v[2*p] ^ v[2*p+1];
            end
            if (s < 3) begin
                for (int i = 0; i < W; i++) v[dst_of(i)] = t[i];
            end else begin
                v = t;
            end
        end
        return v;
    endfunction

    function automatic logic [W-1:0] ref_dec(input logic [W-1:0] q);
        logic [W-1:0] v, t;
        v = q;
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < W / 2; p++) begin
                t[2*p]   = v[2*p] ^ v[2*p+1];
                t[2*p+1] = v[2*p];
            end
            if (s < 3) begin
                for (int i = 0; i < W; i++) v[i] = t[dst_of(i)];
            end else begin
                v = t;
            end
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic mode, input logic [W-1:0] d,
                        input logic [2*W-1:0] exp, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_mode  = mode;
        in_data  = d;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // consumer ready pattern
    initial begin
        out_ready = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            case (rdy_pat)
                0:       out_ready = 1'b1;
                1:       out_ready = (cyc % 3) != 0;
                default: out_ready = 1'b0;
            endcase
        end
    end

    // monitor / scoreboard
    initial begin
        bit held = 0;
        logic [2*W-1:0] held_w = '0;
        wait (mon_on);
        forever begin
            @(negedge clk);
            #2;
            if (held) begin
                // R8: stalled output stays valid and unchanged
                check("R8 hold", {31'd0, out_valid}, 32'd1);
                check("R8 hold word", out_word, held_w);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R7 unexpected output actual=%h expected=none", out_word);
                end else begin
                    string t;
                    logic [2*W-1:0] e;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, out_word, e);
                end
            end
            held   = out_valid && !out_ready;
            held_w = out_word;
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] lfsr;
        logic [W-1:0] pm;
        in_valid = 1'b0;
        in_mode  = 1'b0;
        in_data  = '0;
        rst      = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: reset state
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 in_ready", {31'd0, in_ready}, 32'd1);
        mon_on = 1;

        // directed values, back to back (R9)
        send(1'b0, 16'h0000, 32'h0000_0000, "R2 zero message");
        send(1'b0, 16'h0001, 32'h8000_0001, "R4 single bit 0");
        send(1'b0, 16'h0002, 32'h8080_0002, "R3 single bit 1");
        send(1'b1, 16'h8000, 32'h8000_0001, "R6 decode 8000");
        send(1'b1, 16'h8080, 32'h8080_0002, "R6 decode 8080");
        send(1'b0, 16'hA5C3, {ref_enc(16'hA5C3), 16'hA5C3}, "R5 mode alternation enc");
        idle();
        repeat (2) @(negedge clk);
        #2;
        // R9: drained output goes invalid
        check("R9 drained", {31'd0, out_valid}, 32'd0);

        // stall with a competing word pending (R8)
        rdy_pat = 2;
        @(negedge clk);
        send(1'b0, 16'h1234, {ref_enc(16'h1234), 16'h1234}, "R8 stalled word");
        fork
            send(1'b1, 16'h0F0F, {16'h0F0F, ref_dec(16'h0F0F)}, "R8 queued word");
            begin
                repeat (6) @(negedge clk);
                #3;
                // R7: in_ready low while output is stalled
                check("R7 ready during stall", {31'd0, in_ready}, 32'd0);
                rdy_pat = 0;
            end
        join
        idle();

        // irregular consumer, alternating modes, round trips (R5, R6)
        rdy_pat = 1;
        lfsr = 16'hACE1;
        for (int n = 0; n < 120; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pm = ref_enc(lfsr);
            send(1'b0, lfsr, {pm, lfsr}, "R5 encode");
            send(1'b1, pm, {pm, lfsr}, "R6 round trip");
        end
        idle();
        wait (exp_q.size() == 0);
        rdy_pat = 0;
        repeat (3) @(negedge clk);
        #2;
        check("R9 final idle", {31'd0, out_valid}, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule